// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses which microinstruction a read-only control store delivers next. Each cycle it receives the fields of the control word now being executed, along with a vector of sixteen condition inputs. From these it builds the value for the control-store address register. The word's base-address field supplies the upper address bits directly. Two condition multiplexers supply the two lowest bits. One of them is steered by a high-bit select code. The other is steered by a low-bit select code, but only while the branch-mode field allows it.

When the branch mode is odd, the low-bit select code stops acting mainly as a branch select. It is decoded into a one-hot set of special strobes for the surrounding control logic. In that mode the low address bit is forced to zero for select codes 0 to 13.

The block also runs two parity checks and two sequencing modes:

- It compares the parity bit carried in the word against the parity of the address the word was read from.
- It checks that the whole presented word has odd parity.
- A repeat input freezes the address so that one microinstruction executes again and again.
- A compare-stop mode halts sequencing on the address where the computed next address equals a switch value.

Top module: `mseq_sequencer`

## Requirements
- R1: A synchronous reset loads the address register with the START_ADDR parameter (default 0) and clears the stopped flag and both error flags.
- R2: After any cycle with `cyc_en` high in which the address is loaded, address bits [ADDR_W-1:2] equal the base field that was presented in that cycle.
- R3: Address bit 1 comes from the high select code: code 0 gives 0, code 1 gives 1, and any code k from 2 to 15 gives `cond_i[k]`. This holds in every branch mode.
- R4: When the mode is 0 or 2, address bit 0 follows the same rule, applied to the low select code.
- R5: When the mode is 1 or 3, address bit 0 is 0 for low select codes 0 to 13. Codes 14 and 15 give `cond_i[14]` and `cond_i[15]`.
- R6: `strobe_o` is combinational. While `cyc_en` is high and the mode is 1 or 3, exactly bit `csel_lo_i` is set. Otherwise `strobe_o` is all zeros.
- R7: `apar_err_o` is loaded on every enabled cycle. It is set when `apar_i` differs from the XOR of all bits of the address register as it stood in that cycle.
- R8: `wpar_err_o` is loaded on every enabled cycle. It is set when the XOR of all bits of base, both select codes, mode, `apar_i` and `fill_i` is 0, that is, when the word's parity is even.
- R9: While `repeat_i` is high on an enabled cycle, the address register keeps its value.
- R10: The compare-stop behaves as follows:
  - Suppose `cmp_en_i` is high and the computed next address equals `cmp_addr_i` on an enabled cycle. The address loads that value and `stopped_o` is set.
  - While `stopped_o` and `cmp_en_i` are both high, the address holds.
  - An enabled cycle with `cmp_en_i` low clears `stopped_o` and loads normally.
- R11: With `cyc_en` low, the address register and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cyc_en | input | 1 | Machine-cycle enable; the registers update only when it is high |
| base_i | input | ADDR_W-2 | Base-address field of the current word |
| csel_hi_i | input | 4 | Select code for address bit 1 |
| csel_lo_i | input | 4 | Select code for address bit 0, or strobe code |
| mode_i | input | 2 | Branch-mode field |
| apar_i | input | 1 | Address-parity bit carried in the word |
| fill_i | input | 1 | Bit that keeps the whole word at odd parity |
| cond_i | input | 16 | Condition sources; entries 0 and 1 are unused |
| repeat_i | input | 1 | Hold the current address |
| cmp_en_i | input | 1 | Enable compare-stop |
| cmp_addr_i | input | ADDR_W | Compare-stop switch value |
| addr_o | output | ADDR_W | Address register |
| next_addr_o | output | ADDR_W | Computed next address (combinational) |
| strobe_o | output | 16 | One-hot special strobes |
| apar_err_o | output | 1 | Address-parity mismatch flag |
| wpar_err_o | output | 1 | Word-parity failure flag |
| stopped_o | output | 1 | Compare-stop halt flag |

## Verification
The strobes and the computed next address are combinational. The bench therefore reads them in the same cycle, after driving inputs on the falling edge. The address register, the stopped flag and both parity flags are one register deep. The bench reads them at the falling edge that follows the enabled rising edge, and it compares them against a model that it advances only on enabled, non-held cycles. The address-parity expectation is computed from the model address held before that edge, because the word was read from that address.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
    localparam int SEL_W = 4;
    localparam int NCOND = 2 ** SEL_W;
    localparam int MODE_W = 2;
    localparam logic [SEL_W-1:0] FIRST_SHARED_CODE = 4'd14;

    function automatic logic strobe_mode(input logic [MODE_W-1:0] m);
        return m[0];
    endfunction
endpackage

// File: rtl/mseq_cond_sel.sv
module mseq_cond_sel #(
    parameter int SEL_W = 4,
    localparam int NC = 2 ** SEL_W
) (
    input  logic [NC-1:0]    cond,
    input  logic [SEL_W-1:0] sel,
    output logic             bit_o
);
    always_comb begin
        if (sel == '0)
            bit_o = 1'b0;
        else if (sel == SEL_W'(1))
            bit_o = 1'b1;
        else
            bit_o = cond[sel];
    end
endmodule

// File: rtl/mseq_strobe_dec.sv
module mseq_strobe_dec #(
    parameter int SEL_W = 4,
    localparam int NC = 2 ** SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] code,
    output logic [NC-1:0]    strobe
);
    for (genvar k = 0; k < NC; k++) begin : g_line
        assign strobe[k] = en && (code == SEL_W'(k));
    end
endmodule

// File: rtl/mseq_sequencer.sv
module mseq_sequencer
    import mseq_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] START_ADDR = '0,
    localparam int BASE_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cyc_en,
    input  logic [BASE_W-1:0] base_i,
    input  logic [SEL_W-1:0]  csel_hi_i,
    input  logic [SEL_W-1:0]  csel_lo_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              apar_i,
    input  logic              fill_i,
    input  logic [NCOND-1:0]  cond_i,
    input  logic              repeat_i,
    input  logic              cmp_en_i,
    input  logic [ADDR_W-1:0] cmp_addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [ADDR_W-1:0] next_addr_o,
    output logic [NCOND-1:0]  strobe_o,
    output logic              apar_err_o,
    output logic              wpar_err_o,
    output logic              stopped_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              stop;
        logic              aperr;
        logic              wperr;
    } seq_state_t;

    seq_state_t st_d, st_q;

    logic hi_bit, lo_branch_bit, lo_bit, odd_mode;

    assign odd_mode = strobe_mode(mode_i);

    mseq_cond_sel #(.SEL_W(SEL_W)) u_sel_hi (
        .cond  (cond_i),
        .sel   (csel_hi_i),
        .bit_o (hi_bit)
    );

    mseq_cond_sel #(.SEL_W(SEL_W)) u_sel_lo (
        .cond  (cond_i),
        .sel   (csel_lo_i),
        .bit_o (lo_branch_bit)
    );

    mseq_strobe_dec #(.SEL_W(SEL_W)) u_strobe (
        .en     (cyc_en && odd_mode),
        .code   (csel_lo_i),
        .strobe (strobe_o)
    );

    always_comb begin
        if (!odd_mode)
            lo_bit = lo_branch_bit;
        else if (csel_lo_i >= FIRST_SHARED_CODE)
            lo_bit = cond_i[csel_lo_i];
        else
            lo_bit = 1'b0;
    end

    assign next_addr_o = {base_i, hi_bit, lo_bit};

    always_comb begin
        st_d = st_q;
        if (cyc_en) begin
            st_d.aperr = apar_i ^ (^st_q.addr);
            st_d.wperr = ~(^{base_i, csel_hi_i, csel_lo_i, mode_i, apar_i, fill_i});
            st_d.stop  = cmp_en_i && (st_q.stop || (next_addr_o == cmp_addr_i));
            if (!repeat_i && !(st_q.stop && cmp_en_i))
                st_d.addr = next_addr_o;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.addr  <= START_ADDR;
            st_q.stop  <= 1'b0;
            st_q.aperr <= 1'b0;
            st_q.wperr <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o     = st_q.addr;
    assign stopped_o  = st_q.stop;
    assign apar_err_o = st_q.aperr;
    assign wpar_err_o = st_q.wperr;
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              cyc_en,
    input logic [ADDR_W-3:0] base_i,
    input logic [3:0]        csel_lo_i,
    input logic [1:0]        mode_i,
    input logic              apar_i,
    input logic              repeat_i,
    input logic              cmp_en_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [15:0]       strobe_o,
    input logic              apar_err_o,
    input logic              wpar_err_o,
    input logic              stopped_o
);
    assert_upper_from_base_R2: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && !repeat_i && !stopped_o) |=> addr_o[ADDR_W-1:2] == $past(base_i));

    assert_shared_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && !repeat_i && !stopped_o && mode_i[0] && csel_lo_i < 4'd14) |=> !addr_o[0]);

    assert_strobe_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe_o));

    assert_strobe_gated_R6: assert property (@(posedge clk) disable iff (rst)
        (strobe_o != '0) |-> (cyc_en && mode_i[0] && strobe_o[csel_lo_i]));

    assert_apar_flag_R7: assert property (@(posedge clk) disable iff (rst)
        cyc_en |=> apar_err_o == ($past(apar_i) != ^$past(addr_o)));

    assert_repeat_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && repeat_i) |=> addr_o == $past(addr_o));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        !cyc_en |=> ($stable(addr_o) && $stable(stopped_o) && $stable(apar_err_o) && $stable(wpar_err_o)));

    assert_stop_needs_enable_R10: assert property (@(posedge clk) disable iff (rst)
        (cyc_en && !cmp_en_i) |=> !stopped_o);
endmodule

bind mseq_sequencer mseq_checker #(.ADDR_W(ADDR_W)) u_checker (
    .clk        (clk),
    .rst        (rst),
    .cyc_en     (cyc_en),
    .base_i     (base_i),
    .csel_lo_i  (csel_lo_i),
    .mode_i     (mode_i),
    .apar_i     (apar_i),
    .repeat_i   (repeat_i),
    .cmp_en_i   (cmp_en_i),
    .addr_o     (addr_o),
    .strobe_o   (strobe_o),
    .apar_err_o (apar_err_o),
    .wpar_err_o (wpar_err_o),
    .stopped_o  (stopped_o)
);

// File: tb/mseq_sequencer_test.sv
module mseq_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 12;
    localparam int BW = AW - 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cyc_en = 1'b0;
    logic [BW-1:0] base_i = '0;
    logic [3:0]    csel_hi_i = '0;
    logic [3:0]    csel_lo_i = '0;
    logic [1:0]    mode_i = '0;
    logic          apar_i = 1'b0;
    logic          fill_i = 1'b0;
    logic [15:0]   cond_i = '0;
    logic          repeat_i = 1'b0;
    logic          cmp_en_i = 1'b0;
    logic [AW-1:0] cmp_addr_i = '0;
    logic [AW-1:0] addr_o, next_addr_o;
    logic [15:0]   strobe_o;
    logic          apar_err_o, wpar_err_o, stopped_o;

    int total = 0;
    int bad = 0;
    logic [AW-1:0] m_addr = '0;
    logic          m_stop = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mseq_sequencer #(.ADDR_W(AW)) uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic sel_bit(input logic [3:0] s, input logic [15:0] c);
        if (s == 0) return 1'b0;
        if (s == 1) return 1'b1;
        return c[s];
    endfunction

    // one enabled cycle; bp/bf inject a bad address-parity or bad fill bit
    task automatic step(input logic [BW-1:0] b, input logic [3:0] hi, input logic [3:0] lo,
                        input logic [1:0] md, input logic [15:0] c, input logic bp, input logic bf,
                        input logic rp, input logic ce, input logic [AW-1:0] ca, input string req);
        logic [AW-1:0] nx;
        logic          lb, ap, fl, exp_ap, exp_wp, hit;
        logic [15:0]   exp_strobe;
        @(negedge clk);
        ap = (^m_addr) ^ bp;
        fl = ~(^{b, hi, lo, md, ap}) ^ bf;
        base_i = b; csel_hi_i = hi; csel_lo_i = lo; mode_i = md; cond_i = c;
        apar_i = ap; fill_i = fl; repeat_i = rp; cmp_en_i = ce; cmp_addr_i = ca; cyc_en = 1'b1;
        if (md[0]) lb = (lo >= 4'd14) ? c[lo] : 1'b0;
        else       lb = sel_bit(lo, c);
        nx = {b, sel_bit(hi, c), lb};
        exp_strobe = md[0] ? (16'd1 << lo) : 16'd0;
        #1;
        check({req, " R6 strobe"}, 32'(strobe_o), 32'(exp_strobe));
        check({req, " next"}, 32'(next_addr_o), 32'(nx));
        exp_ap = bp;
        exp_wp = bf;
        hit = ce && (nx == ca);
        if (!rp && !(m_stop && ce)) m_addr = nx;
        m_stop = ce && (m_stop || hit);
        @(negedge clk);
        cyc_en = 1'b0;
        check({req, " addr"}, 32'(addr_o), 32'(m_addr));
        check({req, " R7 apar"}, 32'(apar_err_o), 32'(exp_ap));
        check({req, " R8 wpar"}, 32'(wpar_err_o), 32'(exp_wp));
        check({req, " R10 stop"}, 32'(stopped_o), 32'(m_stop));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int n;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 addr", 32'(addr_o), 32'(0));
        check("R1 flags", 32'({stopped_o, apar_err_o, wpar_err_o}), 32'(0));

        // R2 R3 R4 R5 R6 R7 R8: sweep every mode and both select codes
        n = 0;
        for (int md = 0; md < 4; md++)
            for (int hi = 0; hi < 16; hi++)
                for (int lo = 0; lo < 16; lo++) begin
                    step(BW'(n * 37 + 5), 4'(hi), 4'(lo), 2'(md),
                         16'hA5C3 ^ (16'(n) * 16'h3B1D),
                         (n % 7) == 3, (n % 5) == 2, 1'b0, 1'b0, '0, "R2/R3/R4/R5 sweep");
                    n++;
                end

        // R5 shared codes with all-ones conditions: codes 14/15 follow the condition
        step(BW'(9), 4'd0, 4'd14, 2'd1, 16'hFFFF, 0, 0, 0, 0, '0, "R5 code14");
        check("R5 bit0 set", 32'(addr_o[0]), 32'(1));
        step(BW'(9), 4'd0, 4'd13, 2'd3, 16'hFFFF, 0, 0, 0, 0, '0, "R5 code13");
        check("R5 bit0 zero", 32'(addr_o[0]), 32'(0));

        // R9 repeat hold
        step(BW'(100), 4'd1, 4'd1, 2'd0, '0, 0, 0, 0, 0, '0, "R9 preload");
        step(BW'(200), 4'd0, 4'd0, 2'd0, '0, 0, 0, 1, 0, '0, "R9 hold");
        check("R9 held", 32'(addr_o), 32'({BW'(100), 2'b11}));

        // R11 idle cycles
        @(negedge clk);
        base_i = BW'(7); repeat_i = 1'b0; apar_i = ~apar_i;
        @(negedge clk);
        check("R11 idle addr", 32'(addr_o), 32'(m_addr));
        check("R11 idle flags", 32'(apar_err_o), 32'(0));

        // R10 compare stop: hit, hold, release
        step(BW'(50), 4'd1, 4'd0, 2'd0, '0, 0, 0, 0, 1, {BW'(50), 2'b10}, "R10 hit");
        check("R10 stopped", 32'(stopped_o), 32'(1));
        step(BW'(60), 4'd0, 4'd0, 2'd0, '0, 0, 0, 0, 1, {BW'(50), 2'b10}, "R10 hold");
        check("R10 held", 32'(addr_o), 32'({BW'(50), 2'b10}));
        step(BW'(61), 4'd0, 4'd1, 2'd0, '0, 0, 0, 0, 0, '0, "R10 release");
        check("R10 released", 32'(addr_o), 32'({BW'(61), 2'b01}));

        // R1 reset from a nonzero state
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_addr = '0; m_stop = 1'b0;
        check("R1 re-reset", 32'(addr_o), 32'(0));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule